// File: doc/BRIEF.md
# Phase-Detector Reference Divider

This block turns a slow reference signal, sampled by a fast system clock, into a stream of single-cycle reference events for a phase detector. Reference edges are found by sampling. Each edge that counts is one event. Rising edges always count. When the doubler option is on, falling edges count as well. A programmable counter of ratio R divides the events, and an optional halving stage can divide them by two again. The event rate seen by the phase detector is therefore the reference rate times (1+D)/(R·(1+T)).

Software writes a new ratio, halving bit and doubler bit through a one-cycle write strobe. A write made while the divider runs is held as pending. It becomes active only when the current output period ends, so no period is ever cut short. A write made while powered down becomes active at once. While the block is powered down it ignores the reference and produces no events. When it leaves power-down, the divider starts from a cleared count. A ratio of zero is not legal: it is replaced by one, and a sticky error flag is raised. The status outputs always show the active configuration.

The control is a state machine with three states:
- `ST_OFF`: powered down, count held at zero.
- `ST_FIRST`: counting the first (or only) group of R events.
- `ST_SECOND`: counting the second group of R events when halving is on.

Its transitions are:
- Any state goes to `ST_OFF` while `pwr_down` is high.
- `ST_OFF` goes to `ST_FIRST` once `pwr_down` is low.
- `ST_FIRST` loops to itself on a terminal event with halving off, and this emits a tick.
- `ST_FIRST` goes to `ST_SECOND` on a terminal event with halving on, and this emits no tick.
- `ST_SECOND` goes to `ST_FIRST` on a terminal event, and this emits a tick.

Top module: `refdiv_top`

## Requirements
- R1: With halving and doubler off, `pfd_tick` pulses once for every R rising edges of `ref_in`, for R from 1 to 1023.
- R2: With `stat_t`=1, one tick is produced per 2·R counted events.
- R3: With `stat_d`=1, both rising and falling edges of `ref_in` count as events.
- R4: A `ref_in` edge first seen at rising clock edge k drives `pfd_tick` high from edge k+1 for exactly one clock cycle. Two ticks are never adjacent.
- R5: While `pwr_down` is high, `ref_in` is ignored and `pfd_tick` stays low.
- R6: Leaving power-down clears the event count and the halving stage, so a full fresh period of events is needed before the next tick.
- R7: A configuration written while running is held as pending. It becomes active on the cycle of the next tick, and the status keeps the old values until then.
- R8: A configuration written while powered down appears on `stat_r`, `stat_t` and `stat_d` within two clock cycles.
- R9: Writing `cfg_r`=0 makes the active ratio 1 and sets `cfg_err`. The flag stays set until reset, even after later valid writes.
- R10: After reset, `pfd_tick`=0, `stat_r`=1, `stat_t`=0, `stat_d`=0 and `cfg_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal level, sampled by `clk` |
| pwr_down | input | 1 | High holds the divider off and ignores `ref_in` |
| cfg_we | input | 1 | One-cycle strobe that writes `cfg_r`, `cfg_t` and `cfg_d` |
| cfg_r | input | R_W | Divide ratio R (0 is illegal and is treated as 1) |
| cfg_t | input | 1 | Halving stage enable |
| cfg_d | input | 1 | Doubler enable (count both edges) |
| pfd_tick | output | 1 | Single-cycle reference event to the phase detector |
| stat_r | output | R_W | Active divide ratio |
| stat_t | output | 1 | Active halving bit |
| stat_d | output | 1 | Active doubler bit |
| cfg_err | output | 1 | Sticky flag: a zero ratio was written |

## Verification
A reference edge reaches `pfd_tick` after two registers: the input sampler and the tick register. The bench therefore changes `ref_in` on a falling clock edge and expects the tick at the second falling edge after that. Tick counts are read only after four idle cycles, once every event still in the pipeline has come out. Status changes from a powered-down write take one cycle to stage and one cycle to apply, so the bench waits three cycles before reading them. A write made while running is checked twice: once before the period ends, when the old status must still show, and once after the terminal tick, when the new status must show.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } rdiv_state_e;
endpackage

// File: rtl/refdiv_edge.sv
// Samples the reference and flags counted edges (rising, plus falling when doubling).
module refdiv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic both_edges,
    output logic edge_ev
);
    logic smp_now;
    logic smp_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_now <= ref_in;
            smp_old <= smp_now;
        end
    end

    always_comb begin
        edge_ev = (smp_now & ~smp_old) | (both_edges & ~smp_now & smp_old);
    end
endmodule

// File: rtl/refdiv_cfg.sv
// Pending/active configuration staging with zero-ratio substitution.
module refdiv_cfg #(
    parameter int R_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [R_W-1:0] wr_r,
    input  logic           wr_t,
    input  logic           wr_d,
    input  logic           apply,
    output logic [R_W-1:0] act_r,
    output logic           act_t,
    output logic           act_d,
    output logic           err
);
    localparam logic [R_W-1:0] R_ONE = R_W'(1);

    logic [R_W-1:0] pend_r;
    logic           pend_t;
    logic           pend_d;
    logic           pend_vld;
    logic           wr_zero;

    assign wr_zero = (wr_r == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_r   <= R_ONE;
            pend_t   <= 1'b0;
            pend_d   <= 1'b0;
            pend_vld <= 1'b0;
            act_r    <= R_ONE;
            act_t    <= 1'b0;
            act_d    <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (wr_en) begin
                pend_r   <= wr_zero ? R_ONE : wr_r;
                pend_t   <= wr_t;
                pend_d   <= wr_d;
                pend_vld <= 1'b1;
                if (wr_zero) begin
                    err <= 1'b1;
                end
            end else if (apply && pend_vld) begin
                act_r    <= pend_r;
                act_t    <= pend_t;
                act_d    <= pend_d;
                pend_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/refdiv_fsm.sv
// Event counter and halving state machine.
module refdiv_fsm
    import refdiv_pkg::*;
#(
    parameter int R_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_down,
    input  logic           edge_ev,
    input  logic [R_W-1:0] act_r,
    input  logic           act_t,
    output logic           tick,
    output logic           apply,
    output logic           running
);
    rdiv_state_e    state;
    rdiv_state_e    state_nxt;
    logic [R_W-1:0] cnt;
    logic           at_term;
    logic           grp_done;
    logic           full_term;

    assign at_term   = (cnt == act_r - R_W'(1));
    assign grp_done  = edge_ev && at_term;
    assign full_term = grp_done &&
                       ((state == ST_SECOND) || ((state == ST_FIRST) && !act_t));
    assign apply     = (state == ST_OFF) || full_term;
    assign running   = (state != ST_OFF);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                state_nxt = pwr_down ? ST_OFF : ST_FIRST;
            end
            ST_FIRST: begin
                if (pwr_down) begin
                    state_nxt = ST_OFF;
                end else if (grp_done && act_t) begin
                    state_nxt = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (pwr_down) begin
                    state_nxt = ST_OFF;
                end else if (grp_done) begin
                    state_nxt = ST_FIRST;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // State register and event count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if ((state == ST_OFF) || (state_nxt == ST_OFF)) begin
                cnt <= '0;
            end else if (edge_ev) begin
                cnt <= at_term ? '0 : cnt + R_W'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= full_term && !pwr_down;
        end
    end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int R_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic           pwr_down,
    input  logic           cfg_we,
    input  logic [R_W-1:0] cfg_r,
    input  logic           cfg_t,
    input  logic           cfg_d,
    output logic           pfd_tick,
    output logic [R_W-1:0] stat_r,
    output logic           stat_t,
    output logic           stat_d,
    output logic           cfg_err
);
    logic edge_ev;
    logic apply;
    logic running;

    refdiv_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .both_edges (stat_d),
        .edge_ev    (edge_ev)
    );

    refdiv_cfg #(.R_W(R_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_r   (cfg_r),
        .wr_t   (cfg_t),
        .wr_d   (cfg_d),
        .apply  (apply),
        .act_r  (stat_r),
        .act_t  (stat_t),
        .act_d  (stat_d),
        .err    (cfg_err)
    );

    refdiv_fsm #(.R_W(R_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .edge_ev  (edge_ev),
        .act_r    (stat_r),
        .act_t    (stat_t),
        .tick     (pfd_tick),
        .apply    (apply),
        .running  (running)
    );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
    parameter int R_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_down,
    input logic           cfg_we,
    input logic [R_W-1:0] cfg_r,
    input logic           pfd_tick,
    input logic           running,
    input logic [R_W-1:0] stat_r,
    input logic           stat_t,
    input logic           stat_d,
    input logic           cfg_err
);
    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfd_tick |=> !pfd_tick);

    // R5
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |-> !pfd_tick);

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_r == '0)) |=> cfg_err);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_r != '0);

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({stat_r, stat_t, stat_d}) |-> (pfd_tick || !$past(running)));
endmodule

bind refdiv_top refdiv_chk #(.R_W(R_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .cfg_we   (cfg_we),
    .cfg_r    (cfg_r),
    .pfd_tick (pfd_tick),
    .running  (running),
    .stat_r   (stat_r),
    .stat_t   (stat_t),
    .stat_d   (stat_d),
    .cfg_err  (cfg_err)
);

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;
    localparam int R_W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ref_in = 1'b0;
    logic           pwr_down = 1'b0;
    logic           cfg_we = 1'b0;
    logic [R_W-1:0] cfg_r = '0;
    logic           cfg_t = 1'b0;
    logic           cfg_d = 1'b0;
    logic           pfd_tick;
    logic [R_W-1:0] stat_r;
    logic           stat_t;
    logic           stat_d;
    logic           cfg_err;

    int tests = 0;
    int fails = 0;
    int ticks = 0;
    bit prev_tick = 1'b0;
    bit double_seen = 1'b0;

    always #10 clk = ~clk;

    refdiv_top #(.R_W(R_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .pwr_down (pwr_down),
        .cfg_we   (cfg_we),
        .cfg_r    (cfg_r),
        .cfg_t    (cfg_t),
        .cfg_d    (cfg_d),
        .pfd_tick (pfd_tick),
        .stat_r   (stat_r),
        .stat_t   (stat_t),
        .stat_d   (stat_d),
        .cfg_err  (cfg_err)
    );

    always @(negedge clk) begin
        if (pfd_tick) begin
            ticks = ticks + 1;
            if (prev_tick) double_seen = 1'b1;
        end
        prev_tick = pfd_tick;
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ref_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b1;
            wait_n(2);
            ref_in = 1'b0;
            wait_n(2);
        end
    endtask

    task automatic write_cfg(input int r, input bit t, input bit d);
        cfg_r  = R_W'(r);
        cfg_t  = t;
        cfg_d  = d;
        cfg_we = 1'b1;
        wait_n(1);
        cfg_we = 1'b0;
    endtask

    // Load a configuration while powered down, then resume.
    task automatic load_off(input int r, input bit t, input bit d);
        pwr_down = 1'b1;
        wait_n(2);
        write_cfg(r, t, d);
        wait_n(3);
        pwr_down = 1'b0;
        wait_n(2);
    endtask

    task automatic count_after(input int n, input string tag, input int exp);
        int base;
        base = ticks;
        ref_cycles(n);
        wait_n(4);
        check(tag, ticks - base, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R10 reset state
        check("R10 tick", int'(pfd_tick), 0);
        check("R10 stat_r", int'(stat_r), 1);
        check("R10 stat_t", int'(stat_t), 0);
        check("R10 stat_d", int'(stat_d), 0);
        check("R10 err", int'(cfg_err), 0);

        // R4 latency: tick at second falling edge after drive, one cycle wide
        load_off(1, 1'b0, 1'b0);
        ref_in = 1'b1;
        wait_n(1);
        check("R4 tick before", int'(pfd_tick), 0);
        wait_n(1);
        check("R4 tick due", int'(pfd_tick), 1);
        wait_n(1);
        check("R4 tick width", int'(pfd_tick), 0);
        ref_in = 1'b0;
        wait_n(4);

        // R1 R2 R3 R8 sweep over ratio, halving and doubler
        for (int ri = 0; ri < 5; ri++) begin
            for (int tv = 0; tv < 2; tv++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    int rv;
                    int evs;
                    string tag;
                    rv = (ri == 4) ? 7 : ri + 1;
                    load_off(rv, tv[0], dv[0]);
                    check("R8 stat_r", int'(stat_r), rv);
                    check("R8 stat_t", int'(stat_t), tv);
                    check("R8 stat_d", int'(stat_d), dv);
                    evs = 12 * (1 + dv);
                    tag = (dv != 0) ? "R3 count" : ((tv != 0) ? "R2 count" : "R1 count");
                    count_after(12, tag, evs / (rv * (1 + tv)));
                end
            end
        end

        // R1 R3 boundary: ratio 1023 with both edges
        load_off(1023, 1'b0, 1'b1);
        count_after(511, "R1 1022 events", 0);
        base = ticks;
        ref_in = 1'b1;
        wait_n(4);
        check("R3 1023rd event", ticks - base, 1);
        ref_in = 1'b0;
        wait_n(4);

        // R5 input ignored while powered down
        load_off(1, 1'b0, 1'b0);
        pwr_down = 1'b1;
        wait_n(2);
        count_after(5, "R5 off ticks", 0);
        pwr_down = 1'b0;
        wait_n(2);

        // R6 count cleared on leaving power-down
        load_off(3, 1'b0, 1'b0);
        ref_cycles(1);
        pwr_down = 1'b1;
        wait_n(2);
        pwr_down = 1'b0;
        wait_n(2);
        count_after(2, "R6 count cleared", 0);
        count_after(1, "R6 fresh period", 1);

        // R6 halving stage cleared
        load_off(1, 1'b1, 1'b0);
        ref_cycles(1);
        pwr_down = 1'b1;
        wait_n(2);
        pwr_down = 1'b0;
        wait_n(2);
        count_after(1, "R6 half cleared", 0);
        count_after(1, "R6 half period", 1);

        // R7 write while running waits for the terminal tick
        load_off(3, 1'b0, 1'b0);
        ref_cycles(1);
        write_cfg(5, 1'b0, 1'b0);
        wait_n(2);
        check("R7 old status", int'(stat_r), 3);
        count_after(2, "R7 old period", 1);
        check("R7 new status", int'(stat_r), 5);
        count_after(4, "R7 new partial", 0);
        count_after(1, "R7 new period", 1);

        // R7 write in mid-period with halving
        load_off(2, 1'b1, 1'b0);
        count_after(2, "R7 half boundary", 0);
        write_cfg(1, 1'b0, 1'b0);
        wait_n(2);
        check("R7 halving held", int'(stat_t), 1);
        count_after(2, "R7 halving period", 1);
        check("R7 halving off", int'(stat_t), 0);
        count_after(3, "R7 ratio one", 3);

        // R9 zero ratio
        pwr_down = 1'b1;
        wait_n(2);
        write_cfg(0, 1'b0, 1'b0);
        wait_n(3);
        check("R9 err set", int'(cfg_err), 1);
        check("R9 ratio one", int'(stat_r), 1);
        pwr_down = 1'b0;
        wait_n(2);
        count_after(4, "R9 divide by one", 4);
        load_off(2, 1'b0, 1'b0);
        check("R9 err sticky", int'(cfg_err), 1);
        check("R9 valid ratio", int'(stat_r), 2);

        // R4 no adjacent ticks anywhere in the run
        check("R4 adjacent ticks", int'(double_seen), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule